// File: doc/BRIEF.md
# Instruction Fetch Address Patch Unit

This block sits in the instruction fetch stream between the code memory and the instruction decoder. It holds a small number of programmable byte addresses. When a fetch is issued to one of those addresses and that channel is enabled, the block replaces the fetched code byte with a fixed software-interrupt opcode. The trap then passes control to a patch routine. Fetches from addresses outside the internal code-ROM window are never altered.

The fetch path is a combinational valid/ready pass-through and adds no latency. The upstream side presents `fetch_valid_i` with an address and a data byte. The downstream side accepts the byte when `code_ready_i` is high. `fetch_ready_o` follows `code_ready_i`, and `code_valid_o` follows `fetch_valid_i`. A transfer takes place on a clock edge where both valid and ready are high. While the consumer holds ready low, the producer must hold its address and data stable.

Software programs the unit through a plain register port that has a write strobe and a combinational read. Each match address is written one byte at a time. A channel's comparator becomes active in the cycle after its enable bit is written. Software should therefore clear the enable before it rewrites that channel's address bytes.

Top module: `fetch_patch_unit`

## Requirements
- R1: Each of the two channels holds a 24-bit match address. Register offset 3*c+b holds byte b of channel c (b=0 low bits 7:0, b=1 bits 15:8, b=2 bank bits 23:16). Each byte can be written on its own and read back on `reg_rd_data`.
- R2: Offset 6 is the control register. Bit c enables channel c, and bits 7:2 read back as 0. A channel whose enable bit is 0 never substitutes and never records a hit.
- R3: When an enabled channel's address equals `fetch_addr_i` and the address is inside the ROM window, `code_data_o` is 0x01 in the same cycle.
- R4: The ROM window is ROM_BASE..ROM_LIMIT inclusive (defaults 0xFE0000..0xFEFFFF). A matching address outside it passes the data unchanged and records no hit.
- R5: A fetch that matches no enabled channel passes `fetch_data_i` to `code_data_o` unchanged in the same cycle. Any byte address can be matched, including one that is not the first byte of an instruction.
- R6: When both channels match the same fetch, the output is a single 0x01 byte and both hit bits are set.
- R7: Offset 7 is the status register. Bit c is a sticky hit flag for channel c and is also driven on `hit_o[c]`. The flag is set after an accepted fetch that substitutes because of channel c. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R8: After reset, all address bytes, enables and hit flags are zero.
- R9: A rewrite of an address byte or an enable bit takes effect on the compare from the next cycle on.
- R10: `fetch_ready_o` equals `code_ready_i` and `code_valid_o` equals `fetch_valid_i`. A fetch offered while ready is low records no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write offset |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_addr | input | 3 | Register read offset |
| reg_rd_data | output | 8 | Register read data (combinational) |
| fetch_valid_i | input | 1 | Upstream fetch valid |
| fetch_ready_o | output | 1 | Upstream fetch ready |
| fetch_addr_i | input | 24 | Byte address of the fetch |
| fetch_data_i | input | 8 | Code byte read from memory |
| code_valid_o | output | 1 | Downstream code byte valid |
| code_ready_i | input | 1 | Downstream ready |
| code_data_o | output | 8 | Code byte, possibly substituted |
| hit_o | output | 2 | Sticky per-channel hit flags |

## Verification
The bench sweeps a 16-address window under all four enable combinations, with the two channels two bytes apart. A comparator that ignored its enable, or a channel that answered to the other channel's address, would substitute at the wrong offsets. The bench fetches at the addresses on each side of both ROM window edges. An off-by-one in the window decode would trap just outside the window or pass just inside it. The bench also issues a fetch with ready held low, a clear that lands on the same edge as a set, a rewrite of an address byte while the channel is enabled, and a match on both channels at once. A design that got these wrong would set hits on fetches that were never accepted, lose hits, compare against a stale address, or corrupt the trap byte.

// File: rtl/fpatch_pkg.sv
package fpatch_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {
    SEG_LOW  = 2'd0,
    SEG_MID  = 2'd1,
    SEG_BANK = 2'd2
  } addr_seg_e;
endpackage

// File: rtl/fpatch_chan.sv
module fpatch_chan
  import fpatch_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int REG_AW = 3,
  parameter int CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] addr_o,
  output logic              match_o
);
  localparam int NSEG = ADDR_W / BYTE_W;
  localparam int BASE = CH_IDX * NSEG;

  logic [ADDR_W-1:0] addr_q;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam logic [REG_AW-1:0] OFS = REG_AW'(BASE + s);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        addr_q[s*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && wr_addr == OFS)
        addr_q[s*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  assign addr_o  = addr_q;
  assign match_o = en_i && (fetch_addr == addr_q);

  // R2: a disabled channel never reports a match
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !match_o);

  // R9: a byte write reaches the compare register on the next edge
  p_byte_update_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_AW'(BASE)) |=> addr_q[7:0] == $past(wr_data));
endmodule

// File: rtl/fpatch_rom_dec.sv
module fpatch_rom_dec #(
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 24'hFE0000,
  parameter logic [ADDR_W-1:0] ROM_LIMIT = 24'hFEFFFF
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              in_rom_o
);
  assign in_rom_o = (addr_i >= ROM_BASE) && (addr_i <= ROM_LIMIT);
endmodule

// File: rtl/fpatch_status.sv
module fpatch_status #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] hit_o
);
  logic [NUM_CH-1:0] hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= '0;
    else        hit_q <= (hit_q & ~clr_i) | set_i;
  end

  assign hit_o = hit_q;

  // R7: a flag without a clear stays set
  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((hit_q & $past(hit_q & ~clr_i)) == $past(hit_q & ~clr_i)));

  // R7: a set always lands, even against a clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((hit_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/fetch_patch_unit.sv
module fetch_patch_unit #(
  parameter int                NUM_CH    = 2,
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 24'hFE0000,
  parameter logic [ADDR_W-1:0] ROM_LIMIT = 24'hFEFFFF,
  parameter logic [7:0]        TRAP_OP   = 8'h01,
  parameter int                REG_AW    = $clog2(NUM_CH * (ADDR_W / 8) + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_wr_addr,
  input  logic [7:0]        reg_wr_data,
  input  logic [REG_AW-1:0] reg_rd_addr,
  output logic [7:0]        reg_rd_data,
  input  logic              fetch_valid_i,
  output logic              fetch_ready_o,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [7:0]        fetch_data_i,
  output logic              code_valid_o,
  input  logic              code_ready_i,
  output logic [7:0]        code_data_o,
  output logic [NUM_CH-1:0] hit_o
);
  localparam int NSEG = ADDR_W / 8;
  localparam logic [REG_AW-1:0] CTRL_OFS = REG_AW'(NUM_CH * NSEG);
  localparam logic [REG_AW-1:0] STAT_OFS = REG_AW'(NUM_CH * NSEG + 1);

  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] chan_match;
  logic [ADDR_W-1:0] chan_addr [NUM_CH];
  logic              in_rom;
  logic              accepted;
  logic              substitute;
  logic [NUM_CH-1:0] hit_set;
  logic [NUM_CH-1:0] hit_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   en_q <= '0;
    else if (reg_wr_en && reg_wr_addr == CTRL_OFS) en_q <= reg_wr_data[NUM_CH-1:0];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    fpatch_chan #(.ADDR_W(ADDR_W), .REG_AW(REG_AW), .CH_IDX(c)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr_en),
      .wr_addr   (reg_wr_addr),
      .wr_data   (reg_wr_data),
      .en_i      (en_q[c]),
      .fetch_addr(fetch_addr_i),
      .addr_o    (chan_addr[c]),
      .match_o   (chan_match[c])
    );
  end

  fpatch_rom_dec #(.ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE), .ROM_LIMIT(ROM_LIMIT)) u_rom (
    .addr_i  (fetch_addr_i),
    .in_rom_o(in_rom)
  );

  assign accepted      = fetch_valid_i && code_ready_i;
  assign substitute    = in_rom && (|chan_match);
  assign code_data_o   = substitute ? TRAP_OP : fetch_data_i;
  assign code_valid_o  = fetch_valid_i;
  assign fetch_ready_o = code_ready_i;
  assign hit_set       = chan_match & {NUM_CH{accepted && in_rom}};
  assign hit_clr       = (reg_wr_en && reg_wr_addr == STAT_OFS) ? reg_wr_data[NUM_CH-1:0] : '0;

  fpatch_status #(.NUM_CH(NUM_CH)) u_stat (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(hit_set),
    .clr_i(hit_clr),
    .hit_o(hit_o)
  );

  always_comb begin
    reg_rd_data = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int s = 0; s < NSEG; s++)
        if (reg_rd_addr == REG_AW'(c * NSEG + s))
          reg_rd_data = chan_addr[c][s*8 +: 8];
    if (reg_rd_addr == CTRL_OFS) reg_rd_data[NUM_CH-1:0] = en_q;
    if (reg_rd_addr == STAT_OFS) reg_rd_data[NUM_CH-1:0] = hit_o;
  end

  // R3: an enabled in-window match yields the trap opcode
  p_trap_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_i && in_rom && (|chan_match)) |-> code_data_o == TRAP_OP);

  // R4: fetches outside the ROM window are never altered
  p_outside_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_i && !in_rom) |-> code_data_o == fetch_data_i);

  // R5: no match means pass-through
  p_nomatch_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid_i && !(|chan_match)) |-> code_data_o == fetch_data_i);

  // R10: handshake passes straight through
  p_handshake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid_o == fetch_valid_i) && (fetch_ready_o == code_ready_i));

  // R10: no accepted fetch and no clear leaves the flags alone
  p_stall_noset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!accepted && !(reg_wr_en && reg_wr_addr == STAT_OFS)) |=> $stable(hit_o));
endmodule

// File: tb/fetch_patch_unit_tb_top.sv
module fetch_patch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_addr = '0;
  logic [7:0]  reg_wr_data = '0;
  logic [2:0]  reg_rd_addr = '0;
  logic [7:0]  reg_rd_data;
  logic        fetch_valid_i = 1'b0;
  logic        fetch_ready_o;
  logic [23:0] fetch_addr_i = '0;
  logic [7:0]  fetch_data_i = '0;
  logic        code_valid_o;
  logic        code_ready_i = 1'b1;
  logic [7:0]  code_data_o;
  logic [1:0]  hit_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fetch_patch_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .fetch_valid_i(fetch_valid_i), .fetch_ready_o(fetch_ready_o),
    .fetch_addr_i(fetch_addr_i), .fetch_data_i(fetch_data_i),
    .code_valid_o(code_valid_o), .code_ready_i(code_ready_i),
    .code_data_o(code_data_o), .hit_o(hit_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
    reg_rd_addr = a;
    #1;
    chk(reg_rd_data == e, tag, reg_rd_data, e);
  endtask

  // drive one fetch: check comb output, clock it, then check flags
  task automatic fetch(input logic [23:0] a, input logic [7:0] d, input logic rdy,
                       input logic [7:0] exp_d, input logic [1:0] exp_hit, input string tag);
    @(negedge clk);
    fetch_valid_i = 1'b1; fetch_addr_i = a; fetch_data_i = d; code_ready_i = rdy;
    #1;
    chk(code_data_o == exp_d, tag, code_data_o, exp_d);
    @(negedge clk);
    fetch_valid_i = 1'b0; code_ready_i = 1'b1;
    #1;
    chk(hit_o == exp_hit, {tag, " hit"}, hit_o, exp_hit);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 8'h00, "R8 reset reg");
    chk(hit_o == 2'b00, "R8 reset hit", hit_o, 0);

    // R1: byte-wise write and readback
    for (int a = 0; a < 6; a++) wr(3'(a), 8'(8'h11 * (a + 1)));
    for (int a = 0; a < 6; a++) rd_chk(3'(a), 8'(8'h11 * (a + 1)), "R1 readback");
    wr(3'd6, 8'hFF);
    rd_chk(3'd6, 8'h03, "R2 ctrl readback");
    wr(3'd6, 8'h00);

    // R2 R3 R5: sweep all enable combinations over a 16-byte window
    wr(3'd0, 8'h34); wr(3'd1, 8'h12); wr(3'd2, 8'hFE);   // ch0 FE1234
    wr(3'd3, 8'h36); wr(3'd4, 8'h12); wr(3'd5, 8'hFE);   // ch1 FE1236
    for (int en = 0; en < 4; en++) begin
      wr(3'd6, 8'(en));
      for (int o = 0; o < 16; o++) begin
        logic [23:0] a;
        logic m0, m1;
        logic [7:0] d;
        a = 24'hFE1230 + 24'(o);
        d = a[7:0] ^ 8'h5A;
        m0 = en[0] && a == 24'hFE1234;
        m1 = en[1] && a == 24'hFE1236;
        wr(3'd7, 8'h03);
        fetch(a, d, 1'b1, (m0 || m1) ? 8'h01 : d, {m1, m0}, "R2/R3/R5 sweep");
      end
    end

    // R4: ROM window edges
    wr(3'd6, 8'h00);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFD);   // ch0 FDFFFF (outside)
    wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'hFE);   // ch1 FE0000 (inside)
    wr(3'd6, 8'h03); wr(3'd7, 8'h03);
    fetch(24'hFDFFFF, 8'hA7, 1'b1, 8'hA7, 2'b00, "R4 below base");
    fetch(24'hFE0000, 8'hA8, 1'b1, 8'h01, 2'b10, "R4 at base");
    wr(3'd6, 8'h00);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'hFE);   // ch0 FEFFFF (inside)
    wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'hFF);   // ch1 FF0000 (outside)
    wr(3'd6, 8'h03); wr(3'd7, 8'h03);
    fetch(24'hFEFFFF, 8'hB1, 1'b1, 8'h01, 2'b01, "R4 at limit");
    fetch(24'hFF0000, 8'hB2, 1'b1, 8'hB2, 2'b01, "R4 above limit");

    // R6: both channels on the same address
    wr(3'd6, 8'h00);
    wr(3'd0, 8'h00); wr(3'd1, 8'h40); wr(3'd2, 8'hFE);
    wr(3'd3, 8'h00); wr(3'd4, 8'h40); wr(3'd5, 8'hFE);
    wr(3'd6, 8'h03); wr(3'd7, 8'h03);
    fetch(24'hFE4000, 8'hC3, 1'b1, 8'h01, 2'b11, "R6 dual match");

    // R7: write 0 keeps, write 1 clears only that bit
    wr(3'd7, 8'h00);
    chk(hit_o == 2'b11, "R7 write0 keeps", hit_o, 3);
    wr(3'd7, 8'h01);
    rd_chk(3'd7, 8'h02, "R7 w1c ch0");
    // R7: set in the same cycle as a clear wins
    @(negedge clk);
    fetch_valid_i = 1'b1; fetch_addr_i = 24'hFE4000; fetch_data_i = 8'h00;
    reg_wr_en = 1'b1; reg_wr_addr = 3'd7; reg_wr_data = 8'h03;
    @(negedge clk);
    fetch_valid_i = 1'b0; reg_wr_en = 1'b0;
    #1;
    chk(hit_o == 2'b11, "R7 set wins over clear", hit_o, 3);

    // R10: stalled fetch substitutes data but records no hit
    wr(3'd7, 8'h03);
    @(negedge clk);
    fetch_valid_i = 1'b1; fetch_addr_i = 24'hFE4000; code_ready_i = 1'b0;
    #1;
    chk(fetch_ready_o == 1'b0 && code_valid_o == 1'b1, "R10 handshake", {fetch_ready_o, code_valid_o}, 1);
    @(negedge clk);
    fetch_valid_i = 1'b0; code_ready_i = 1'b1;
    #1;
    chk(hit_o == 2'b00, "R10 stall no hit", hit_o, 0);

    // R9: rewrite low byte while enabled takes effect next cycle; non-first byte matched
    wr(3'd0, 8'h01);                                     // ch0 FE4001
    wr(3'd3, 8'h77);                                     // ch1 FE4077
    wr(3'd7, 8'h03);
    fetch(24'hFE4000, 8'h4A, 1'b1, 8'h4A, 2'b00, "R9 old addr gone");
    fetch(24'hFE4001, 8'h80, 1'b1, 8'h01, 2'b01, "R9 new addr live");
    wr(3'd6, 8'h00); wr(3'd7, 8'h03);
    fetch(24'hFE4001, 8'h80, 1'b1, 8'h80, 2'b00, "R2 disabled after write");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule